// File: doc/BRIEF.md
# Per-Bank Manual Refresh Scheduler

This block keeps the contents of a four-bank SDRAM alive without the all-bank auto-refresh command. It does so by refreshing a single bank at a time. The controller's command arbiter opens the row the block names and then issues a dummy read with auto-precharge. The returned data is discarded. Because only one bank is ever taken, the other banks keep serving normal traffic while that bank is refreshed.

A shared interval timer adds one unit of refresh debt to every bank per interval. Each bank keeps a saturating debt counter and its own row counter. A bank asks for service when it owes refreshes and its window input is high, so refreshes can be gathered into idle stretches such as video blanking. Once a bank's debt reaches an urgent threshold it asks regardless of its window, which bounds how long refresh can be put off. Each bank also takes a last-row input, so it can refresh only a leading part of its rows and leave unused rows to decay.

The block presents one bank at a time to the arbiter. It drives a one-hot request, the bank index, the row address and an urgent flag, all from registers. A refresh counts as done on a cycle where the request bit and the grant bit of the same bank are both high.

Top module: `bank_refresh_sched`

## Requirements
- R1: Reset clears every bank's debt and row counter. While reset is high, and on the first cycle after it, `ref_req` is 0 and `ref_urgent` is 0.
- R2: Every `INTERVAL` clock cycles after reset is released, the debt of every bank grows by one. With all windows high, a request first appears in the cycle after the `INTERVAL`-th rising edge, and not one cycle earlier.
- R3: A bank whose debt is below `URGENT` is requested only while its window bit in `refresh_win` is high. The request reacts to the window one cycle later. Debt keeps building while the window is low.
- R4: A bank whose debt is at least `URGENT` is requested even with its window low, and `ref_urgent` is 1 while that bank is presented.
- R5: At most one bit of `ref_req` is high. `ref_bank` is the index of that bit. When a new bank is picked, urgent banks win over banks that are only windowed, and among equals the lowest bank index wins.
- R6: A cycle where `ref_req[b]` and `ref_gnt[b]` are both high completes one refresh of bank b. Its debt drops by one and its row counter moves to the next row. Grant bits of banks that are not requested have no effect.
- R7: A bank's row counter returns to 0 after a refresh of the row equal to that bank's field in `row_last_flat` (bank b uses bits [b*ROW_W +: ROW_W]).
- R8: While a request is not granted and the same bank stays requested, `ref_bank` and `ref_row` do not change. The presented bank is kept until it is granted or stops wanting service, even if another bank becomes urgent.
- R9: Debt saturates at 2^DEBT_W-1 and does not wrap.
- R10: An interval tick and a grant of the same bank in the same cycle leave that bank's debt unchanged, while the row still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_win | input | NUM_BANKS | Per-bank idle window; high allows non-urgent refresh |
| row_last_flat | input | NUM_BANKS*ROW_W | Per-bank last refreshed row, static |
| ref_gnt | input | NUM_BANKS | Per-bank grant from the command arbiter |
| ref_req | output | NUM_BANKS | One-hot refresh request |
| ref_urgent | output | 1 | Presented bank has reached the urgent debt |
| ref_bank | output | $clog2(NUM_BANKS) | Bank to activate and read |
| ref_row | output | ROW_W | Row to activate in that bank |

## Verification
The two functions that can land in the same cycle are the interval tick, which raises every bank's debt, and a grant, which lowers the debt of the presented bank. The bench holds off the grant of an urgent bank and releases it exactly on the rising edge where the tick falls. It then judges the net debt by watching which bank is presented on the following cycles. If the debt stayed at the urgent level, bank 0 is presented again after the edge and needs exactly one more grant before it gives way. A debt that was lost or counted twice changes that order. The same order-of-service observation is used to judge saturation, after a long stretch with no grants.

// File: rtl/rsched_pkg.sv
package rsched_pkg;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int first_set(input logic [31:0] v);
    int idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/rsched_tick.sv
module rsched_tick #(
  parameter int INTERVAL = 750
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rsched_bank.sv
module rsched_bank #(
  parameter int ROW_W  = 13,
  parameter int DEBT_W = 4,
  parameter int URGENT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             fire,
  input  logic             win,
  input  logic [ROW_W-1:0] row_last,
  output logic             want_nx,
  output logic             urgent_nx,
  output logic [ROW_W-1:0] row_nx
);
  localparam logic [DEBT_W-1:0] DMAX = '1;
  localparam logic [DEBT_W-1:0] DURG = DEBT_W'(URGENT);

  logic [DEBT_W-1:0] debt_q, debt_nx;
  logic [ROW_W-1:0]  row_q;

  always_comb begin
    unique case ({tick, fire})
      2'b10:   debt_nx = (debt_q == DMAX) ? debt_q : debt_q + 1'b1;
      2'b01:   debt_nx = (debt_q == '0)   ? debt_q : debt_q - 1'b1;
      default: debt_nx = debt_q;
    endcase
  end

  always_comb begin
    if (!fire)                 row_nx = row_q;
    else if (row_q == row_last) row_nx = '0;
    else                       row_nx = row_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      debt_q <= '0;
      row_q  <= '0;
    end else begin
      debt_q <= debt_nx;
      row_q  <= row_nx;
    end
  end

  assign urgent_nx = (debt_nx >= DURG) && (debt_nx != '0);
  assign want_nx   = (debt_nx != '0) && (win || urgent_nx);
endmodule

// File: rtl/rsched_select.sv
module rsched_select
  import rsched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NB-1:0]       want,
  input  logic [NB-1:0]       urg,
  input  logic [NB*ROW_W-1:0] rows,
  input  logic                fire_any,
  output logic [NB-1:0]       req,
  output logic                urgent,
  output logic [BW-1:0]       bank,
  output logic [ROW_W-1:0]    row
);
  logic          val_q, val_nx;
  logic [BW-1:0] sel_q, sel_nx;
  logic [NB-1:0] hot;
  logic          keep;

  assign hot  = want & urg;
  assign keep = val_q && !fire_any && want[sel_q];

  always_comb begin
    if (keep) begin
      val_nx = 1'b1;
      sel_nx = sel_q;
    end else if (|hot) begin
      val_nx = 1'b1;
      sel_nx = BW'(first_set(32'(hot)));
    end else if (|want) begin
      val_nx = 1'b1;
      sel_nx = BW'(first_set(32'(want)));
    end else begin
      val_nx = 1'b0;
      sel_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= 1'b0;
      sel_q  <= '0;
      req    <= '0;
      urgent <= 1'b0;
      row    <= '0;
    end else begin
      val_q  <= val_nx;
      sel_q  <= sel_nx;
      req    <= val_nx ? (NB'(1) << sel_nx) : '0;
      urgent <= val_nx && urg[sel_nx];
      row    <= rows[int'(sel_nx)*ROW_W +: ROW_W];
    end
  end

  assign bank = sel_q;
endmodule

// File: rtl/bank_refresh_sched.sv
module bank_refresh_sched #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int INTERVAL  = 750,
  parameter int DEBT_W    = 4,
  parameter int URGENT    = 8,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS-1:0]       refresh_win,
  input  logic [NUM_BANKS*ROW_W-1:0] row_last_flat,
  input  logic [NUM_BANKS-1:0]       ref_gnt,
  output logic [NUM_BANKS-1:0]       ref_req,
  output logic                       ref_urgent,
  output logic [BW-1:0]              ref_bank,
  output logic [ROW_W-1:0]           ref_row
);
  logic                       tick;
  logic [NUM_BANKS-1:0]       fire, want, urg;
  logic [NUM_BANKS*ROW_W-1:0] rows;

  assign fire = ref_req & ref_gnt;

  rsched_tick #(.INTERVAL(INTERVAL)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rsched_bank #(
      .ROW_W  (ROW_W),
      .DEBT_W (DEBT_W),
      .URGENT (URGENT)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .fire      (fire[b]),
      .win       (refresh_win[b]),
      .row_last  (row_last_flat[b*ROW_W +: ROW_W]),
      .want_nx   (want[b]),
      .urgent_nx (urg[b]),
      .row_nx    (rows[b*ROW_W +: ROW_W])
    );
  end

  rsched_select #(.NB(NUM_BANKS), .ROW_W(ROW_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .want     (want),
    .urg      (urg),
    .rows     (rows),
    .fire_any (|fire),
    .req      (ref_req),
    .urgent   (ref_urgent),
    .bank     (ref_bank),
    .row      (ref_row)
  );
endmodule

// File: rtl/rsched_checker.sv
module rsched_checker #(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NB-1:0]    refresh_win,
  input logic [NB-1:0]    ref_gnt,
  input logic [NB-1:0]    ref_req,
  input logic             ref_urgent,
  input logic [BW-1:0]    ref_bank,
  input logic [ROW_W-1:0] ref_row
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ref_req)); // R5

  AST_BANK_MATCH: assert property (@(posedge clk) disable iff (rst)
    (|ref_req) |-> ref_req[ref_bank]); // R5

  AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> (|ref_req)); // R4

  AST_WINDOW_GATE: assert property (@(posedge clk) disable iff (rst)
    ((|ref_req) && !ref_urgent) |-> (|($past(refresh_win) & ref_req))); // R3

  AST_HOLD_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
    ((|ref_req) && !(|(ref_req & ref_gnt))) |=>
      ((ref_req != $past(ref_req)) || ($stable(ref_bank) && $stable(ref_row)))); // R8
endmodule

bind bank_refresh_sched rsched_checker #(
  .NB    (NUM_BANKS),
  .ROW_W (ROW_W),
  .BW    (BW)
) u_rsched_chk (
  .clk         (clk),
  .rst         (rst),
  .refresh_win (refresh_win),
  .ref_gnt     (ref_gnt),
  .ref_req     (ref_req),
  .ref_urgent  (ref_urgent),
  .ref_bank    (ref_bank),
  .ref_row     (ref_row)
);

// File: tb/test_bank_refresh_sched.sv
`timescale 1ns/1ps
module test_bank_refresh_sched;
  localparam int NB = 4, RW = 4, IV = 32, DW = 3, UG = 4;

  typedef struct packed {
    logic [9:0] e;
    logic [3:0] win, gnt, req, row;
    logic       urg;
    logic [3:0] tag;
  } vec_t;

  // target edge, window, grant, expected req / row / urgent, requirement
  localparam vec_t VECS [24] = '{
    '{10'd5,   4'h0, 4'h0, 4'h0, 4'd0, 1'b0, 4'd2},  // R2 no debt yet
    '{10'd32,  4'hF, 4'h0, 4'h1, 4'd0, 1'b0, 4'd2},  // R2 first tick
    '{10'd35,  4'hF, 4'h0, 4'h1, 4'd0, 1'b0, 4'd8},  // R8 held
    '{10'd36,  4'hF, 4'h1, 4'h2, 4'd0, 1'b0, 4'd6},  // R6 bank0 done
    '{10'd37,  4'hF, 4'h2, 4'h4, 4'd0, 1'b0, 4'd6},  // R6
    '{10'd38,  4'hF, 4'h4, 4'h8, 4'd0, 1'b0, 4'd5},  // R5 order
    '{10'd39,  4'hF, 4'h8, 4'h0, 4'd0, 1'b0, 4'd6},  // R6 all paid
    '{10'd64,  4'h0, 4'h0, 4'h0, 4'd0, 1'b0, 4'd3},  // R3 window low
    '{10'd128, 4'h0, 4'h0, 4'h0, 4'd0, 1'b0, 4'd3},  // R3 debt 3
    '{10'd160, 4'h0, 4'h0, 4'h1, 4'd1, 1'b1, 4'd4},  // R4 urgent, row advanced
    '{10'd161, 4'h0, 4'hF, 4'h2, 4'd1, 1'b1, 4'd4},  // R4
    '{10'd162, 4'h0, 4'hF, 4'h4, 4'd1, 1'b1, 4'd6},  // R6
    '{10'd164, 4'h0, 4'hF, 4'h0, 4'd0, 1'b0, 4'd6},  // R6 back under threshold
    '{10'd165, 4'h2, 4'h0, 4'h2, 4'd2, 1'b0, 4'd3},  // R3 window opens
    '{10'd166, 4'h2, 4'h2, 4'h2, 4'd0, 1'b0, 4'd7},  // R7 wrap at last row 2
    '{10'd167, 4'h0, 4'h0, 4'h0, 4'd0, 1'b0, 4'd3},  // R3 window closes
    '{10'd192, 4'h0, 4'h0, 4'h1, 4'd2, 1'b1, 4'd5},  // R5 lowest urgent
    '{10'd223, 4'h0, 4'h0, 4'h1, 4'd2, 1'b1, 4'd8},  // R8 held while others urgent
    '{10'd224, 4'h0, 4'h1, 4'h1, 4'd3, 1'b1, 4'd10}, // R10 tick with grant
    '{10'd225, 4'h0, 4'h1, 4'h2, 4'd0, 1'b1, 4'd10}, // R10 one grant left
    '{10'd352, 4'h0, 4'h0, 4'h2, 4'd0, 1'b1, 4'd8},  // R8 long hold
    '{10'd357, 4'h0, 4'hF, 4'h2, 4'd1, 1'b1, 4'd9},  // R9 bank0 paid 4
    '{10'd367, 4'h0, 4'hF, 4'h8, 4'd5, 1'b1, 4'd9},  // R9 bank3 still urgent
    '{10'd368, 4'h0, 4'hF, 4'h0, 4'd0, 1'b0, 4'd9}   // R9 saturated at 7
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NB-1:0]  win = '0, gnt = '0;
  logic [NB*RW-1:0] row_last = {4'd15, 4'd15, 4'd2, 4'd15};
  logic [NB-1:0]  ref_req;
  logic           ref_urgent;
  logic [1:0]     ref_bank;
  logic [RW-1:0]  ref_row;

  int checks = 0, errors = 0, edges = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_refresh_sched #(
    .NUM_BANKS(NB), .ROW_W(RW), .INTERVAL(IV), .DEBT_W(DW), .URGENT(UG)
  ) i_bank_refresh_sched (
    .clk(clk), .rst(rst), .refresh_win(win), .row_last_flat(row_last),
    .ref_gnt(gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_bank(ref_bank), .ref_row(ref_row)
  );

  task automatic check(input int r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d (edge %0d)", r, what, act, exp, edges);
    end
  endtask

  task automatic run_to(input int target);
    while (edges < target) begin
      @(posedge clk);
      edges++;
    end
    @(negedge clk);
  endtask

  function automatic int oh_idx(input logic [3:0] v);
    int k;
    k = 0;
    for (int i = 0; i < 4; i++) if (v[i]) k = i;
    return k;
  endfunction

  task automatic expect_out(input int r, input logic [3:0] req, input logic [3:0] row, input logic urg);
    check(r, "req", int'(ref_req), int'(req));
    check(r, "urgent", int'(ref_urgent), int'(urg));
    if (req != 0) begin
      check(r, "bank", int'(ref_bank), oh_idx(req));
      check(r, "row", int'(ref_row), int'(row));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out(1, 4'h0, 4'd0, 1'b0); // R1 in reset
    rst = 1'b0;
    edges = 0;
    for (int i = 0; i < 24; i++) begin
      win = VECS[i].win;
      gnt = VECS[i].gnt;
      run_to(int'(VECS[i].e));
      expect_out(int'(VECS[i].tag), VECS[i].req, VECS[i].row, VECS[i].urg);
    end
    // R1: reset mid-run clears rows and debt
    gnt = '0; win = '0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_out(1, 4'h0, 4'd0, 1'b0);
    rst = 1'b0; win = 4'hF; edges = 0;
    run_to(1);
    expect_out(1, 4'h0, 4'd0, 1'b0);          // R1 first cycle after reset
    run_to(31);
    expect_out(2, 4'h0, 4'd0, 1'b0);          // R2 not before the interval
    run_to(32);
    expect_out(1, 4'h1, 4'd0, 1'b0);          // R1 bank0 row cleared
    gnt = 4'h1;
    run_to(33);
    expect_out(1, 4'h2, 4'd0, 1'b0);          // R1 bank1 row cleared
    gnt = 4'hD;                               // R6 grants to unrequested banks
    run_to(35);
    expect_out(6, 4'h2, 4'd0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at edge %0d", edges);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule